// File: doc/BRIEF.md
# Masked-Write Strap and Link-Status Register Bank

This block is the small register bank that sits between a simple APB-style register port and a PCIe controller core. It holds the strap settings that the core samples: generation select, port role, lane count, alternate routing ID enable, single-root virtualization enable, link-training enable and configuration enable. It drives each of these out as its own wire. It also reports the two-bit link state that the core produces, and it holds a mask for the four legacy INTx inputs. Those four inputs are combined into a single interrupt line.

Each writable register takes its write enables from the upper half of the write word. Bit n of the lower half changes only when bit n+16 of the write data is set. Software can therefore flip one field with a single write, without reading the register first. The bank does not decode any other register. Accesses to other offsets read as zero and do not change any state.

Top module: `strap_status_bank`

## Requirements
- R1: Under synchronous active-low reset, every strap bit and every mask bit is 0. All strap outputs are low, and a read of the strap or mask register returns 0.
- R2: A write to the strap register (offset 0x000) or the mask register (offset 0x04C) changes bit n (n < 16) only when write-data bit n+16 is 1. When that enable bit is set, bit n takes write-data bit n. Every other bit keeps its value.
- R3: The strap register drives the outputs from these bits: bit 7 `gen2_sel_o` (1 = Gen2), bit 6 `root_port_o` (1 = root port), bits 5:4 `lane_log2_o` (log2 of the lane count), bit 3 `ari_en_o`, bit 2 `sriov_en_o`, bit 1 `train_en_o`, bit 0 `cfg_en_o`.
- R4: If a write would leave lane field bits 5:4 at 3, that field keeps its previous value. The other fields in the same write still apply. The legal values are 0, 1 and 2 (x1, x2 and x4).
- R5: Reads of the strap and mask registers return 0 in bits 31:16 and in every bit that holds no field. Writes to those bits have no effect.
- R6: The link-status register (offset 0x048) reads `link_state_i` in bits 21:20 and 0 in all other bits. The encoding is 0 = no receivers, 1 = training, 2 = link up with data-link init running, 3 = link up with data-link init done. Writes to this register change nothing.
- R7: Mask bits 8:5 belong to INTA, INTB, INTC and INTD (`intx_i[0]` to `intx_i[3]`). A mask bit of 1 masks its input and 0 enables it. `intx_irq_o` is high exactly when some unmasked input is high.
- R8: A read of any other offset returns 0, and a write to any other offset leaves all registers unchanged.
- R9: A write takes effect only in a cycle with `psel_i`, `penable_i` and `pwrite_i` all high. `prdata_o` is 0 unless `psel_i` is high and `pwrite_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| psel_i | input | 1 | Register port select |
| penable_i | input | 1 | Access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W (12) | Byte offset |
| pwdata_i | input | 32 | Write data; bits 31:16 are per-bit enables |
| prdata_o | output | 32 | Read data, combinational |
| link_state_i | input | 2 | Link state from the core |
| intx_i | input | 4 | Legacy INTA..INTD levels |
| gen2_sel_o | output | 1 | Generation select strap |
| root_port_o | output | 1 | Port role strap |
| lane_log2_o | output | 2 | Lane count strap, log2 |
| ari_en_o | output | 1 | Alternate routing ID enable strap |
| sriov_en_o | output | 1 | Virtualization enable strap |
| train_en_o | output | 1 | Link-training enable strap |
| cfg_en_o | output | 1 | Configuration enable strap |
| intx_irq_o | output | 1 | Combined unmasked legacy interrupt |

## Verification
The bench sends writes whose enable half selects only some of the bits. A design that ignored the enables would overwrite the fields that were not selected. A design that shifted the enables by the wrong amount would change the wrong neighbours. It tries to set the lane field to 3 with both of its enable bits set, and again by enabling a single bit so that the merged value becomes 3. A design that checked only the raw write value would let the second case through. It writes only to the reserved bits of the mask register, writes to the status and unmapped offsets, and sends a setup-phase-only write. Each of these shows up as an unexpected change on readback or on the strap pins. It also drives INTx patterns against partial masks, where a mask whose polarity or bit order was wrong would raise or drop the interrupt line.

// File: rtl/sbank_pkg.sv
// Package sbank_pkg
// Shared constants for the strap/status register bank: data width, the split
// between data half and enable half, field positions and the link-state code.
package sbank_pkg;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;

    // strap field positions (decoded by the core, so fixed)
    localparam int STRAP_W  = 8;
    localparam int GEN_BIT  = 7;
    localparam int ROLE_BIT = 6;
    localparam int LANE_HI  = 5;
    localparam int LANE_LO  = 4;
    localparam int ARI_BIT  = 3;
    localparam int SRIOV_BIT = 2;
    localparam int TRAIN_BIT = 1;
    localparam int CFG_BIT  = 0;

    // interrupt mask field
    localparam int NUM_INTX = 4;
    localparam int MASK_LSB = 5;

    // link state field in the status word
    localparam int LS_LSB   = 20;

    typedef enum logic [1:0] {
        LS_NO_RX   = 2'd0,
        LS_TRAIN   = 2'd1,
        LS_DL_INIT = 2'd2,
        LS_DL_DONE = 2'd3
    } link_state_e;

    localparam logic [1:0] LANE_ILLEGAL = 2'd3;
endpackage

// File: rtl/sbank_masked_reg.sv
// Module sbank_masked_reg
// A register with one write enable per bit. On a write strobe, each bit whose
// enable is set loads its data bit, and the other bits hold.
// Assumes the caller has already extracted the data and enable halves.
module sbank_masked_reg #(
    parameter int             WIDTH = 8,
    parameter logic [WIDTH-1:0] RESET = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [WIDTH-1:0] wdata_i,
    input  logic [WIDTH-1:0] wen_i,
    output logic [WIDTH-1:0] q_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // per-bit storage: reset, load when enabled, else hold
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                q_o[i] <= RESET[i];
            else if (wr_i && wen_i[i])
                q_o[i] <= wdata_i[i];
        end
    end

    // R1
    reset_value_chk: assert property (@(posedge clk_i) !rst_ni |=> (q_o == RESET));
    // R2
    enabled_bits_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((q_o & $past(wen_i)) == ($past(wdata_i) & $past(wen_i))));
    // R2
    disabled_bits_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> ((q_o & ~$past(wen_i)) == ($past(q_o) & ~$past(wen_i))));
    // R9
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !wr_i |=> $stable(q_o));
endmodule

// File: rtl/sbank_intx_gate.sv
// Module sbank_intx_gate
// Combines the legacy interrupt levels with their mask bits.
// A mask bit of 1 blocks its input. The output is the OR of the unblocked inputs.
module sbank_intx_gate #(
    parameter int N = 4
) (
    input  logic [N-1:0] intx_i,
    input  logic [N-1:0] mask_i,
    output logic         irq_o
);
    // any unmasked level raises the line
    always_comb irq_o = |(intx_i & ~mask_i);
endmodule

// File: rtl/strap_status_bank.sv
// Module strap_status_bank
// Register bank for a PCIe controller: strap register, link-status register
// and legacy interrupt mask. Writable registers take per-bit enables
// from write-data bits 31:16. The bank assumes a single-beat APB-style port
// and samples an access when psel and penable are both high. Reads are combinational.
module strap_status_bank
    import sbank_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] STRAP_OFS = ADDR_W'('h000),
    parameter logic [ADDR_W-1:0] STAT_OFS  = ADDR_W'('h048),
    parameter logic [ADDR_W-1:0] MASK_OFS  = ADDR_W'('h04C)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [31:0]       pwdata_i,
    output logic [31:0]       prdata_o,
    input  logic [1:0]        link_state_i,
    input  logic [3:0]        intx_i,
    output logic              gen2_sel_o,
    output logic              root_port_o,
    output logic [1:0]        lane_log2_o,
    output logic              ari_en_o,
    output logic              sriov_en_o,
    output logic              train_en_o,
    output logic              cfg_en_o,
    output logic              intx_irq_o
);
    localparam int MASK_MSB = MASK_LSB + NUM_INTX - 1;

    logic                wr_acc;
    logic                rd_acc;
    logic                hit_strap, hit_stat, hit_mask;
    logic [HALF_W-1:0]   wd_lo, we_hi;
    logic [STRAP_W-1:0]  strap_q, strap_wen;
    logic [NUM_INTX-1:0] mask_q;
    logic [1:0]          lane_merged;
    logic                unused_bits;

    // access qualification and address decode
    always_comb begin
        wr_acc    = psel_i && penable_i && pwrite_i;
        rd_acc    = psel_i && !pwrite_i;
        hit_strap = (paddr_i == STRAP_OFS);
        hit_stat  = (paddr_i == STAT_OFS);
        hit_mask  = (paddr_i == MASK_OFS);
        wd_lo     = pwdata_i[HALF_W-1:0];
        we_hi     = pwdata_i[DATA_W-1:HALF_W];
    end

    // lane field guard: drop the lane enables if the merge would give 3
    always_comb begin
        lane_merged = (strap_q[LANE_HI:LANE_LO] & ~we_hi[LANE_HI:LANE_LO])
                    | (wd_lo[LANE_HI:LANE_LO] & we_hi[LANE_HI:LANE_LO]);
        strap_wen = we_hi[STRAP_W-1:0];
        if (lane_merged == LANE_ILLEGAL)
            strap_wen[LANE_HI:LANE_LO] = 2'b00;
    end

    sbank_masked_reg #(.WIDTH(STRAP_W), .RESET('0)) u_strap (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_acc && hit_strap),
        .wdata_i (wd_lo[STRAP_W-1:0]),
        .wen_i   (strap_wen),
        .q_o     (strap_q)
    );

    sbank_masked_reg #(.WIDTH(NUM_INTX), .RESET('0)) u_mask (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_acc && hit_mask),
        .wdata_i (wd_lo[MASK_MSB:MASK_LSB]),
        .wen_i   (we_hi[MASK_MSB:MASK_LSB]),
        .q_o     (mask_q)
    );

    sbank_intx_gate #(.N(NUM_INTX)) u_intx (
        .intx_i (intx_i),
        .mask_i (mask_q),
        .irq_o  (intx_irq_o)
    );

    // strap outputs straight from the stored fields
    always_comb begin
        gen2_sel_o  = strap_q[GEN_BIT];
        root_port_o = strap_q[ROLE_BIT];
        lane_log2_o = strap_q[LANE_HI:LANE_LO];
        ari_en_o    = strap_q[ARI_BIT];
        sriov_en_o  = strap_q[SRIOV_BIT];
        train_en_o  = strap_q[TRAIN_BIT];
        cfg_en_o    = strap_q[CFG_BIT];
    end

    // read mux: zero unless a selected read hits a mapped offset
    always_comb begin
        prdata_o = '0;
        if (rd_acc) begin
            if (hit_strap)
                prdata_o[STRAP_W-1:0] = strap_q;
            else if (hit_stat)
                prdata_o[LS_LSB+1:LS_LSB] = link_state_i;
            else if (hit_mask)
                prdata_o[MASK_MSB:MASK_LSB] = mask_q;
        end
    end

    assign unused_bits = ^{wd_lo[HALF_W-1:MASK_MSB+1], we_hi[HALF_W-1:MASK_MSB+1]};

    // R4
    lane_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lane_log2_o != LANE_ILLEGAL);
    // R4
    lane_reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && hit_strap && lane_merged == LANE_ILLEGAL) |=> $stable(lane_log2_o));
    // R5
    upper_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_acc && !hit_stat) |-> (prdata_o[31:16] == 16'h0));
    // R6
    status_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_acc && hit_stat) |-> (prdata_o == {10'h0, link_state_i, 20'h0}));
    // R7
    all_masked_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask_q) |-> !intx_irq_o);
    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_acc && !hit_strap && !hit_stat && !hit_mask) |-> (prdata_o == 32'h0));
    // R8
    unmapped_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_acc && !hit_strap && !hit_mask) |=> ($stable(strap_q) && $stable(mask_q)));
endmodule

// File: tb/strap_status_bank_bench.sv
`timescale 1ns/1ps
module strap_status_bank_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic [1:0]  link_state = 2'd2;
    logic [3:0]  intx = '0;
    logic gen2, role, ari, sriov, train, cfg, irq;
    logic [1:0] lane;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    strap_status_bank u_strap_status_bank (
        .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
        .link_state_i(link_state), .intx_i(intx), .gen2_sel_o(gen2),
        .root_port_o(role), .lane_log2_o(lane), .ari_en_o(ari),
        .sriov_en_o(sriov), .train_en_o(train), .cfg_en_o(cfg), .intx_irq_o(irq)
    );

    // vector: {req, write, addr, wdata, expected read}
    localparam int NV = 33;
    localparam logic [80:0] VEC [NV] = '{
        {4'd2, 1'b1, 12'h000, 32'h00FF00C3, 32'h0},
        {4'd5, 1'b0, 12'h000, 32'h0, 32'h000000C3},        // R5 R2
        {4'd2, 1'b1, 12'h000, 32'h00300020, 32'h0},
        {4'd2, 1'b0, 12'h000, 32'h0, 32'h000000E3},        // R2
        {4'd4, 1'b1, 12'h000, 32'h00300030, 32'h0},
        {4'd4, 1'b0, 12'h000, 32'h0, 32'h000000E3},        // R4 lane 3 rejected
        {4'd4, 1'b1, 12'h000, 32'h00100010, 32'h0},
        {4'd4, 1'b0, 12'h000, 32'h0, 32'h000000E3},        // R4 merged 3 rejected
        {4'd2, 1'b1, 12'h000, 32'h00810000, 32'h0},
        {4'd2, 1'b0, 12'h000, 32'h0, 32'h00000062},        // R2
        {4'd2, 1'b1, 12'h000, 32'h0000FFFF, 32'h0},
        {4'd2, 1'b0, 12'h000, 32'h0, 32'h00000062},        // R2 no enables
        {4'd2, 1'b1, 12'h000, 32'h000CFFFF, 32'h0},
        {4'd2, 1'b0, 12'h000, 32'h0, 32'h0000006E},        // R2
        {4'd7, 1'b1, 12'h04C, 32'h01E001E0, 32'h0},
        {4'd7, 1'b0, 12'h04C, 32'h0, 32'h000001E0},        // R7
        {4'd7, 1'b1, 12'h04C, 32'h00200000, 32'h0},
        {4'd7, 1'b0, 12'h04C, 32'h0, 32'h000001C0},        // R7
        {4'd5, 1'b1, 12'h04C, 32'hFE1FFFFF, 32'h0},
        {4'd5, 1'b0, 12'h04C, 32'h0, 32'h000001C0},        // R5 reserved bits
        {4'd6, 1'b0, 12'h048, 32'h0, 32'h00200000},        // R6
        {4'd6, 1'b1, 12'h048, 32'hFFFFFFFF, 32'h0},
        {4'd6, 1'b0, 12'h048, 32'h0, 32'h00200000},        // R6 write ignored
        {4'd8, 1'b1, 12'h040, 32'hFFFFFFFF, 32'h0},
        {4'd8, 1'b0, 12'h040, 32'h0, 32'h00000000},        // R8
        {4'd8, 1'b0, 12'h044, 32'h0, 32'h00000000},        // R8
        {4'd8, 1'b1, 12'h008, 32'hFFFFFFFF, 32'h0},
        {4'd8, 1'b0, 12'h000, 32'h0, 32'h0000006E},        // R8
        {4'd8, 1'b0, 12'h04C, 32'h0, 32'h000001C0},        // R8
        {4'd2, 1'b1, 12'h000, 32'h00200010, 32'h0},
        {4'd2, 1'b0, 12'h000, 32'h0, 32'h0000004E},        // R2 bit4 not enabled
        {4'd4, 1'b1, 12'h000, 32'h00110011, 32'h0},
        {4'd4, 1'b0, 12'h000, 32'h0, 32'h0000005F}         // R4 lane 1 legal
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b1;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 straps", {25'h0, gen2, role, lane, ari, sriov, train, cfg}, 32'h0);
        rst_n = 1'b1;
        do_read(12'h000, rd); check("R1 strap read", rd, 32'h0);
        do_read(12'h04C, rd); check("R1 mask read", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][76]) do_write(VEC[i][75:64], VEC[i][63:32]);
            else begin
                do_read(VEC[i][75:64], rd);
                check($sformatf("R%0d vector %0d", VEC[i][80:77], i), rd, VEC[i][31:0]);
            end
        end

        // R3 strap pins for 0x5F
        check("R3 pins", {25'h0, gen2, role, lane, ari, sriov, train, cfg}, 32'h0000005F);
        do_write(12'h000, 32'h00800080);
        check("R3 gen2 pin", {31'h0, gen2}, 32'h1);

        // R7 mask 0x1C0: INTA enabled, INTB..D masked
        @(negedge clk); intx = 4'b0001; #1 check("R7 INTA unmasked", {31'h0, irq}, 32'h1);
        @(negedge clk); intx = 4'b1110; #1 check("R7 B..D masked", {31'h0, irq}, 32'h0);
        do_write(12'h04C, 32'h01E00000);
        @(negedge clk); intx = 4'b1000; #1 check("R7 INTD unmasked", {31'h0, irq}, 32'h1);
        do_write(12'h04C, 32'h008000C0);
        @(negedge clk); intx = 4'b0100; #1 check("R7 INTC partial", {31'h0, irq}, 32'h0);
        @(negedge clk); intx = 4'b1011; #1 check("R7 others", {31'h0, irq}, 32'h1);
        intx = 4'b0000;

        // R6 link state encodings
        link_state = 2'd3; do_read(12'h048, rd); check("R6 state 3", rd, 32'h00300000);
        link_state = 2'd0; do_read(12'h048, rd); check("R6 state 0", rd, 32'h0);

        // R9 setup-phase-only write and penable without psel
        @(negedge clk); psel = 1'b1; pwrite = 1'b1; paddr = 12'h000; pwdata = 32'h00FF0000;
        @(negedge clk); psel = 1'b0; penable = 1'b1;
        @(negedge clk); penable = 1'b0; pwrite = 1'b0;
        do_read(12'h000, rd); check("R9 no access", rd, 32'h000000DF);
        @(negedge clk); psel = 1'b0; pwrite = 1'b0; paddr = 12'h000; #1
        check("R9 idle read zero", prdata, 32'h0);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 pins after reset", {25'h0, gen2, role, lane, ari, sriov, train, cfg}, 32'h0);
        do_read(12'h04C, rd); check("R1 mask after reset", rd, 32'h0);
        finish_run();
    end
endmodule